// File: doc/BRIEF.md
# Out-of-Order Issue Window Scheduler

This block keeps a pool of up to 32 instructions that decode has already renamed and that are waiting for their operands. Each slot holds a destination physical tag and two source tags, and each source has its own ready flag. Decode writes one instruction per cycle into a free slot. The block raises a full signal when no slot is free.

Executing instructions broadcast their result tags on a set of wakeup ports. Any waiting source whose tag matches a broadcast becomes ready. Each cycle the scheduler picks up to two instructions whose sources are both ready and sends them to execution. Selection follows dependence readiness, not program order. When several instructions are ready, the ones allocated earliest win. A picked slot is released at the next clock edge. A flush, used on a branch misprediction, empties the whole pool.

Top module: `iw_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, no issue lane is valid and `full_o` is low.
- R2: When `alloc_vld_i` is high, `full_o` is low and `flush_i` is low, exactly one instruction enters the window at the clock edge. It can be issued no earlier than the following cycle.
- R3: `full_o` is high exactly when all 32 slots hold an instruction. An allocation request made while `full_o` is high creates no entry, and that instruction never issues.
- R4: An instruction may issue only when both of its sources are ready. A source flagged ready at allocation needs no wakeup, so an instruction with both flags set issues in the cycle after allocation when it is among the two oldest ready instructions.
- R5: A valid wakeup port carrying a tag equal to a waiting source tag marks that source ready at the clock edge. The instruction can then issue in the next cycle. Both wakeup ports act in the same cycle.
- R6: An instruction allocated in the same cycle as a broadcast that matches one of its source tags captures that wakeup. It does not wait for a later broadcast.
- R7: At most two instructions issue per cycle. Lane 0 carries the oldest ready instruction by allocation order, and lane 1 carries the next oldest ready one.
- R8: An issued instruction leaves the window at the clock edge that ends its issue cycle and never issues again.
- R9: While `flush_i` is high, no issue lane is valid and an allocation in that cycle is dropped. After the edge the window is empty.
- R10: Issue lane 1 is never valid unless lane 0 is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empties the window at the next edge and blocks issue this cycle |
| alloc_vld_i | input | 1 | Decode presents an instruction |
| alloc_dst_i | input | 7 | Destination physical tag |
| alloc_srca_i | input | 7 | First source physical tag |
| alloc_srca_rdy_i | input | 1 | First source already available |
| alloc_srcb_i | input | 7 | Second source physical tag |
| alloc_srcb_rdy_i | input | 1 | Second source already available |
| full_o | output | 1 | No free slot; allocation is refused |
| wake_vld_i | input | 2 | One valid bit per result broadcast port |
| wake_tag_i | input | 2x7 | Broadcast result tag per port |
| iss_vld_o | output | 2 | Issue lane valid, lane 0 oldest |
| iss_dst_o | output | 2x7 | Destination tag of the instruction on each lane |

## Verification
Directed patterns come first. Instructions that are ready at allocation isolate the plain allocate-to-issue latency. Instructions that wait on one shared tag show whether a single broadcast releases a whole group, two per cycle in age order. A broadcast that coincides with allocation separates capture from a missed wakeup. Filling the window beyond 32 entries checks the full boundary and shows that refused requests leave no trace. Flushes that land on a cycle with ready instructions check the issue gating and the clearing. A long random stream then mixes overlapping wakeups, refills after flush and slot reuse. This stream exposes stale age bits, which only show up when freed slots are reallocated out of order.

// File: rtl/iw_pkg.sv
package iw_pkg;

    // physical register tag width shared by the scheduler and its neighbours
    parameter int unsigned TAG_W = 7;

    typedef logic [TAG_W-1:0] ptag_t;

    typedef struct packed {
        ptag_t tag;
        logic  rdy;
    } src_t;

    typedef struct packed {
        ptag_t dst;
        src_t  a;
        src_t  b;
    } slot_t;

endpackage

// File: rtl/iw_oldest_pick.sv
// Grants the single requester that no other requester is older than.
// older_i[j][i] set means slot j was allocated before slot i.
module iw_oldest_pick #(
    parameter int unsigned NUM_ENTRIES = 32
) (
    input  logic [NUM_ENTRIES-1:0]                  req_i,
    input  logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] older_i,
    output logic [NUM_ENTRIES-1:0]                  gnt_o
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        logic [NUM_ENTRIES-1:0] col;
        always_comb begin
            for (int j = 0; j < NUM_ENTRIES; j++) begin
                col[j] = older_i[j][i];
            end
        end
        assign gnt_o[i] = req_i[i] & ~(|(req_i & col));
    end

endmodule

// File: rtl/iw_free_find.sv
// Lowest-numbered unoccupied slot.
module iw_free_find #(
    parameter int unsigned NUM_ENTRIES = 32,
    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] busy_i,
    output logic                   found_o,
    output logic [IDX_W-1:0]       idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/iw_sched.sv
module iw_sched
    import iw_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 32,
    parameter int unsigned ISSUE_W     = 2,
    parameter int unsigned WAKE_W      = 2
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            flush_i,
    input  logic                            alloc_vld_i,
    input  logic [TAG_W-1:0]                alloc_dst_i,
    input  logic [TAG_W-1:0]                alloc_srca_i,
    input  logic                            alloc_srca_rdy_i,
    input  logic [TAG_W-1:0]                alloc_srcb_i,
    input  logic                            alloc_srcb_rdy_i,
    output logic                            full_o,
    input  logic [WAKE_W-1:0]               wake_vld_i,
    input  logic [WAKE_W-1:0][TAG_W-1:0]    wake_tag_i,
    output logic [ISSUE_W-1:0]              iss_vld_o,
    output logic [ISSUE_W-1:0][TAG_W-1:0]   iss_dst_o
);

    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

    typedef struct packed {
        logic  [NUM_ENTRIES-1:0]                  vld;
        slot_t [NUM_ENTRIES-1:0]                  slot;
        logic  [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] older;
    } win_t;

    win_t st_d, st_q;

    logic [NUM_ENTRIES-1:0]              rdy;
    logic [ISSUE_W-1:0][NUM_ENTRIES-1:0] lane_req;
    logic [ISSUE_W-1:0][NUM_ENTRIES-1:0] gnt;
    logic [NUM_ENTRIES-1:0]              gnt_any;
    logic                                free_found;
    logic [IDX_W-1:0]                    free_idx;
    slot_t                               nslot;

    function automatic logic woken(ptag_t t,
                                   logic [WAKE_W-1:0] v,
                                   logic [WAKE_W-1:0][TAG_W-1:0] tg);
        logic h;
        h = 1'b0;
        for (int p = 0; p < WAKE_W; p++) begin
            h = h | (v[p] && (tg[p] == t));
        end
        return h;
    endfunction

    // ready-to-issue vector from registered state only
    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            rdy[i] = st_q.vld[i] & st_q.slot[i].a.rdy & st_q.slot[i].b.rdy;
        end
    end

    // chain of pickers: each lane sees the requests the older lanes left
    for (genvar k = 0; k < ISSUE_W; k++) begin : g_lane
        if (k == 0) begin : g_first
            assign lane_req[k] = rdy & {NUM_ENTRIES{~flush_i}};
        end else begin : g_next
            assign lane_req[k] = lane_req[k-1] & ~gnt[k-1];
        end
        iw_oldest_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
            .req_i   (lane_req[k]),
            .older_i (st_q.older),
            .gnt_o   (gnt[k])
        );
    end

    always_comb begin
        gnt_any = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            iss_vld_o[k] = |gnt[k];
            iss_dst_o[k] = '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (gnt[k][i]) begin
                    iss_dst_o[k] = iss_dst_o[k] | st_q.slot[i].dst;
                end
            end
            gnt_any = gnt_any | gnt[k];
        end
    end

    iw_free_find #(.NUM_ENTRIES(NUM_ENTRIES)) u_free (
        .busy_i  (st_q.vld),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    assign full_o = ~free_found;

    // incoming instruction, with same-cycle wakeup capture
    always_comb begin
        nslot.dst   = alloc_dst_i;
        nslot.a.tag = alloc_srca_i;
        nslot.a.rdy = alloc_srca_rdy_i | woken(alloc_srca_i, wake_vld_i, wake_tag_i);
        nslot.b.tag = alloc_srcb_i;
        nslot.b.rdy = alloc_srcb_rdy_i | woken(alloc_srcb_i, wake_vld_i, wake_tag_i);
    end

    always_comb begin
        st_d = st_q;

        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (gnt_any[i]) begin
                st_d.vld[i] = 1'b0;
            end
            if (woken(st_q.slot[i].a.tag, wake_vld_i, wake_tag_i)) begin
                st_d.slot[i].a.rdy = 1'b1;
            end
            if (woken(st_q.slot[i].b.tag, wake_vld_i, wake_tag_i)) begin
                st_d.slot[i].b.rdy = 1'b1;
            end
        end

        if (alloc_vld_i && free_found) begin
            st_d.slot[free_idx] = nslot;
            st_d.vld[free_idx]  = 1'b1;
            for (int j = 0; j < NUM_ENTRIES; j++) begin
                st_d.older[j][free_idx] = st_q.vld[j];
                st_d.older[free_idx][j] = 1'b0;
            end
        end

        if (flush_i) begin
            st_d.vld = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/iw_sched_chk.sv
module iw_sched_chk
    import iw_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 32,
    parameter int unsigned ISSUE_W     = 2,
    parameter int unsigned WAKE_W      = 2
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          flush_i,
    input logic                          alloc_vld_i,
    input logic                          full_o,
    input logic [ISSUE_W-1:0]            iss_vld_o
);

    localparam int unsigned CNT_W = $clog2(NUM_ENTRIES + 1);

    logic [CNT_W-1:0] occ_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            occ_q <= '0;
        end else if (flush_i) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q - CNT_W'($countones(iss_vld_o))
                           + CNT_W'(alloc_vld_i && !full_o);
        end
    end

    // R3
    full_matches_occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_o == (occ_q == CNT_W'(NUM_ENTRIES)));

    // R9
    flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (iss_vld_o == '0) && !full_o);

    // R9
    flush_blocks_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> iss_vld_o == '0);

    // R10
    lane_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_vld_o[1] |-> iss_vld_o[0]);

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> (iss_vld_o == '0) && !full_o);

endmodule

bind iw_sched iw_sched_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ISSUE_W     (ISSUE_W),
    .WAKE_W      (WAKE_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .alloc_vld_i (alloc_vld_i),
    .full_o      (full_o),
    .iss_vld_o   (iss_vld_o)
);

// File: tb/test_iw_sched.sv
module test_iw_sched;
    import iw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 32;
    localparam int ISW = 2;
    localparam int WKW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic a_vld = 1'b0;
    logic [TAG_W-1:0] a_dst = '0, a_sa = '0, a_sb = '0;
    logic a_ra = 1'b0, a_rb = 1'b0;
    logic full;
    logic [WKW-1:0] wk_vld = '0;
    logic [WKW-1:0][TAG_W-1:0] wk_tag = '0;
    logic [ISW-1:0] iss_vld;
    logic [ISW-1:0][TAG_W-1:0] iss_dst;

    int checks = 0;
    int errors = 0;
    int dst_ctr = 0;

    typedef struct {
        int dst; int sa; int sb; bit ra; bit rb;
    } ent_t;
    ent_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    iw_sched #(.NUM_ENTRIES(N), .ISSUE_W(ISW), .WAKE_W(WKW)) i_iw_sched (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .alloc_vld_i(a_vld), .alloc_dst_i(a_dst),
        .alloc_srca_i(a_sa), .alloc_srca_rdy_i(a_ra),
        .alloc_srcb_i(a_sb), .alloc_srcb_rdy_i(a_rb),
        .full_o(full), .wake_vld_i(wk_vld), .wake_tag_i(wk_tag),
        .iss_vld_o(iss_vld), .iss_dst_o(iss_dst)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic bit hitw(int t);
        for (int p = 0; p < WKW; p++) begin
            if (wk_vld[p] && int'(wk_tag[p]) == t) return 1'b1;
        end
        return 1'b0;
    endfunction

    // called at a negedge with inputs set; checks, advances model, waits one cycle
    task automatic step(input string rq);
        int pick[$];
        bit was_full;
        #1;
        if (!flush) begin
            for (int i = 0; i < q.size() && pick.size() < ISW; i++) begin
                if (q[i].ra && q[i].rb) pick.push_back(i);
            end
        end
        for (int l = 0; l < ISW; l++) begin
            bit ev;
            ev = (l < pick.size());
            chk(iss_vld[l] == ev, rq, $sformatf("lane%0d valid", l), int'(iss_vld[l]), int'(ev));
            if (ev && iss_vld[l]) begin
                chk(int'(iss_dst[l]) == q[pick[l]].dst, rq, $sformatf("lane%0d dst", l),
                    int'(iss_dst[l]), q[pick[l]].dst);
            end
        end
        was_full = (q.size() == N);
        chk(full == was_full, "R3", "full", int'(full), int'(was_full));
        chk(!(iss_vld[1] && !iss_vld[0]), "R10", "lane1 without lane0", int'(iss_vld), 1);
        if (!rst_n || flush) begin
            q.delete();
        end else begin
            for (int i = pick.size() - 1; i >= 0; i--) q.delete(pick[i]);
            for (int i = 0; i < q.size(); i++) begin
                if (hitw(q[i].sa)) q[i].ra = 1'b1;
                if (hitw(q[i].sb)) q[i].rb = 1'b1;
            end
            if (a_vld && !was_full) begin
                ent_t e;
                e.dst = int'(a_dst); e.sa = int'(a_sa); e.sb = int'(a_sb);
                e.ra = a_ra | hitw(int'(a_sa));
                e.rb = a_rb | hitw(int'(a_sb));
                q.push_back(e);
            end
        end
        @(negedge clk);
        a_vld = 1'b0; flush = 1'b0; wk_vld = '0; a_ra = 1'b0; a_rb = 1'b0;
    endtask

    task automatic put(input int sa, input bit ra, input int sb, input bit rb);
        a_vld = 1'b1;
        a_dst = TAG_W'(dst_ctr); dst_ctr = (dst_ctr + 1) % 128;
        a_sa = TAG_W'(sa); a_ra = ra; a_sb = TAG_W'(sb); a_rb = rb;
    endtask

    task automatic wake(input int p, input int t);
        wk_vld[p] = 1'b1; wk_tag[p] = TAG_W'(t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step("R1");
        step("R1");
        rst_n = 1'b1;
        step("R1");

        // R2 / R4: ready at allocation, issues one cycle later
        for (int i = 0; i < 4; i++) begin put(1, 1, 2, 1); step("R2"); end
        step("R4");

        // R5: group waiting on tags 100 and 101
        for (int i = 0; i < 5; i++) begin put(100, 0, 101 - (i % 2), i % 2); step("R5"); end
        wake(0, 100); step("R5");
        wake(1, 101); step("R5");
        for (int i = 0; i < 4; i++) step("R7");

        // R6: broadcast in the allocation cycle
        put(50, 0, 51, 1); wake(1, 50); step("R6");
        step("R6");
        put(52, 0, 53, 0); wake(0, 52); wake(1, 53); step("R6");
        step("R6");

        // R3: overfill with waiting instructions, then release
        for (int i = 0; i < 36; i++) begin put(120 + (i % 4), 0, 3, 1); step("R3"); end
        put(1, 1, 1, 1); step("R3");
        wake(0, 122); wake(1, 123); step("R5");
        for (int i = 0; i < 10; i++) step("R7");
        wake(0, 120); step("R5");
        wake(1, 121); step("R5");
        for (int i = 0; i < 14; i++) step("R8");

        // R9: flush while instructions are ready, allocation dropped
        for (int i = 0; i < 6; i++) begin put(70, 0, 71, 1); step("R9"); end
        wake(0, 70); step("R9");
        flush = 1'b1; put(1, 1, 1, 1); step("R9");
        for (int i = 0; i < 3; i++) step("R9");

        // R7: random mix
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 3) != 0)
                put($urandom_range(0, 15), $urandom_range(0, 1) == 0,
                    $urandom_range(0, 15), $urandom_range(0, 1) == 0);
            for (int p = 0; p < WKW; p++)
                if ($urandom_range(0, 2) == 0) wake(p, $urandom_range(0, 15));
            if ($urandom_range(0, 63) == 0) flush = 1'b1;
            step("R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule